// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec

This block is a digital adaptive delta modulator with its matching demodulator. On each sample strobe the encoder compares a signed PCM input sample with its own reconstructed estimate. It emits one bit that says whether the estimate should rise or fall, and it moves the estimate by a step whose size adapts to the recent bit history. The decoder receives that bit stream on a separate strobe. It repeats the same step adaptation and the same estimate update, so its output is the reconstructed waveform.

The step grows by one half of itself when a bit repeats the previous bit. It shrinks to about two thirds of itself when the bit alternates. Both operations use only shifts and adds, and the result is kept between a minimum and a maximum step. The estimate saturates at the signed sample limits instead of wrapping. The decoder needs no synchronisation, so a corrupted bit only bends the slope locally.

Top module: `adm_codec`

## Requirements
- R1: On a cycle with `sample_valid` high, `enc_bit` becomes 1 after the clock edge if `sample_in` is greater than or equal to the current `enc_est`, and 0 otherwise.
- R2: When an encoder or decoder bit is 1 the estimate rises by the adapted step, and when it is 0 the estimate falls by the adapted step. The adapted step is computed from this same bit, and saturation (R6) still applies.
- R3: When a bit equals the previous bit of the same side, the new step is `step + (step >> 1)`.
- R4: When a bit differs from the previous bit of the same side, the new step is `(step >> 1) + (step >> 3) + (step >> 5)`.
- R5: The step is clamped to the range `STEP_MIN` to `STEP_MAX` after every update, so one estimate change never exceeds `STEP_MAX`.
- R6: The estimate saturates at the most positive and the most negative value of `SAMPLE_W` signed bits and never wraps.
- R7: A synchronous active-low reset sets, on both sides, the step to `STEP_MIN`, the estimate to 0 and the previous bit to 0. It also sets `enc_bit` to 0.
- R8: Without a strobe on its side, the encoder outputs or the decoder output hold their values whatever `sample_in` or `dec_bit` carry.
- R9: Fed the encoder's bits one per strobe with no errors, `dec_sample` repeats the sequence of `enc_est`.
- R10: A corrupted received bit is decoded like any other bit, with no stall and no resynchronisation. Later outputs follow from the bits as received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Encoder sample strobe |
| sample_in | input | SAMPLE_W | Signed PCM input sample |
| enc_bit | output | 1 | Encoded delta bit (1 = step up) |
| enc_est | output | SAMPLE_W | Encoder's internal reconstructed estimate |
| dec_valid | input | 1 | Decoder bit strobe |
| dec_bit | input | 1 | Received delta bit |
| dec_sample | output | SAMPLE_W | Decoder's reconstructed sample |

## Verification
A flat zero input makes the bit alternate and the step fall to its minimum. This separates the shrink path and its lower clamp from the growth path. Full-scale positive and negative inputs produce long runs that drive the step to its maximum and the estimate into both saturation limits. Random samples and slow ramps mix both adaptation paths at every step size. Streams with single flipped bits show that the decoder keeps decoding the bits exactly as received, while idle cycles with changing inputs show that nothing moves without a strobe.

// File: rtl/adm_pkg.sv
// Shared types for the adaptive delta modulation codec.
package adm_pkg;
    // Direction carried by one delta bit.
    typedef enum logic {
        ADM_DOWN = 1'b0,
        ADM_UP   = 1'b1
    } adm_dir_e;
endpackage

// File: rtl/adm_step_calc.sv
// Step adaptation: grows by x1.5 on a repeated bit, shrinks by ~x0.66 on an
// alternating bit, then clamps to [STEP_MIN, STEP_MAX].
// Assumes 1 <= STEP_MIN <= STEP_MAX < 2**STEP_W.
module adm_step_calc #(
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 8,
    parameter int STEP_MAX = 8192
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              repeat_i,
    output logic [STEP_W-1:0] step_o
);
    localparam int EW = STEP_W + 1;
    localparam logic [EW-1:0] MIN_E = EW'(STEP_MIN);
    localparam logic [EW-1:0] MAX_E = EW'(STEP_MAX);

    logic [EW-1:0] wide;
    logic [EW-1:0] grow;
    logic [EW-1:0] shrink;

    // Shift-and-add scaling of the step in both directions.
    always_comb begin
        wide   = {1'b0, step_i};
        grow   = wide + (wide >> 1);
        shrink = (wide >> 1) + (wide >> 3) + (wide >> 5);
    end

    // Pick the scaled value and clamp it to the legal step range.
    always_comb begin
        logic [EW-1:0] pick;
        pick = repeat_i ? grow : shrink;
        if (pick > MAX_E) begin
            step_o = MAX_E[STEP_W-1:0];
        end else if (pick < MIN_E) begin
            step_o = MIN_E[STEP_W-1:0];
        end else begin
            step_o = pick[STEP_W-1:0];
        end
    end
endmodule

// File: rtl/adm_core.sv
// Shared tracking state of one codec side: step, previous bit and estimate.
// On each advance it adapts the step from the new bit and moves the estimate
// by the adapted step, saturating at the signed range. Assumes STEP_W < SAMPLE_W.
module adm_core
    import adm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 8,
    parameter int STEP_MAX = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       advance,
    input  adm_dir_e                   dir,
    output logic signed [SAMPLE_W-1:0] est_o
);
    localparam int XW = SAMPLE_W + 2;
    localparam logic signed [XW-1:0] EST_HI = {3'b000, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [XW-1:0] EST_LO = {3'b111, {(SAMPLE_W-1){1'b0}}};

    logic [STEP_W-1:0]          step_q;
    logic [STEP_W-1:0]          step_d;
    adm_dir_e                   prev_q;
    logic signed [SAMPLE_W-1:0] est_q;
    logic signed [SAMPLE_W-1:0] est_d;
    logic signed [XW-1:0]       base;
    logic signed [XW-1:0]       delta;
    logic signed [XW-1:0]       sum;

    adm_step_calc #(
        .STEP_W  (STEP_W),
        .STEP_MIN(STEP_MIN),
        .STEP_MAX(STEP_MAX)
    ) u_calc (
        .step_i  (step_q),
        .repeat_i(dir == prev_q),
        .step_o  (step_d)
    );

    // Move the estimate by the adapted step and saturate it.
    always_comb begin
        base  = {{2{est_q[SAMPLE_W-1]}}, est_q};
        delta = {{(XW-STEP_W){1'b0}}, step_d};
        sum   = (dir == ADM_UP) ? (base + delta) : (base - delta);
        if (sum > EST_HI) begin
            est_d = EST_HI[SAMPLE_W-1:0];
        end else if (sum < EST_LO) begin
            est_d = EST_LO[SAMPLE_W-1:0];
        end else begin
            est_d = sum[SAMPLE_W-1:0];
        end
    end

    // Tracking state registers, updated only on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= STEP_W'(STEP_MIN);
            prev_q <= ADM_DOWN;
            est_q  <= '0;
        end else if (advance) begin
            step_q <= step_d;
            prev_q <= dir;
            est_q  <= est_d;
        end
    end

    assign est_o = est_q;
endmodule

// File: rtl/adm_encoder.sv
// Encoder side: compares the sample with the local estimate, registers the
// resulting bit and advances its tracking core with that bit.
module adm_encoder
    import adm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 8,
    parameter int STEP_MAX = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       bit_o,
    output logic signed [SAMPLE_W-1:0] est_o
);
    adm_dir_e dir;
    logic     bit_q;

    // Sign of (sample - estimate); zero difference counts as up.
    always_comb dir = (sample >= est_o) ? ADM_UP : ADM_DOWN;

    adm_core #(
        .SAMPLE_W(SAMPLE_W),
        .STEP_W  (STEP_W),
        .STEP_MIN(STEP_MIN),
        .STEP_MAX(STEP_MAX)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(strobe),
        .dir    (dir),
        .est_o  (est_o)
    );

    // Hold the emitted bit until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (strobe) begin
            bit_q <= (dir == ADM_UP);
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/adm_decoder.sv
// Decoder side: replays received bits through an identical tracking core.
module adm_decoder
    import adm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 8,
    parameter int STEP_MAX = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic                       bit_i,
    output logic signed [SAMPLE_W-1:0] est_o
);
    adm_dir_e dir;

    // Map the received bit onto a step direction.
    always_comb dir = bit_i ? ADM_UP : ADM_DOWN;

    adm_core #(
        .SAMPLE_W(SAMPLE_W),
        .STEP_W  (STEP_W),
        .STEP_MIN(STEP_MIN),
        .STEP_MAX(STEP_MAX)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(strobe),
        .dir    (dir),
        .est_o  (est_o)
    );
endmodule

// File: rtl/adm_codec.sv
// Adaptive delta modulation codec top: encoder and decoder side by side,
// with independent strobes so the bit link can be delayed or corrupted.
module adm_codec #(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 8,
    parameter int STEP_MAX = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic                       enc_bit,
    output logic signed [SAMPLE_W-1:0] enc_est,
    input  logic                       dec_valid,
    input  logic                       dec_bit,
    output logic signed [SAMPLE_W-1:0] dec_sample
);
    adm_encoder #(
        .SAMPLE_W(SAMPLE_W),
        .STEP_W  (STEP_W),
        .STEP_MIN(STEP_MIN),
        .STEP_MAX(STEP_MAX)
    ) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(sample_valid),
        .sample(sample_in),
        .bit_o (enc_bit),
        .est_o (enc_est)
    );

    adm_decoder #(
        .SAMPLE_W(SAMPLE_W),
        .STEP_W  (STEP_W),
        .STEP_MIN(STEP_MIN),
        .STEP_MAX(STEP_MAX)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(dec_valid),
        .bit_i (dec_bit),
        .est_o (dec_sample)
    );
endmodule

// File: rtl/adm_codec_checker.sv
// Port-level temporal checks for adm_codec, attached by bind.
module adm_codec_checker #(
    parameter int SAMPLE_W = 16,
    parameter int STEP_MAX = 8192
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sample_valid,
    input logic signed [SAMPLE_W-1:0] sample_in,
    input logic                       enc_bit,
    input logic signed [SAMPLE_W-1:0] enc_est,
    input logic                       dec_valid,
    input logic signed [SAMPLE_W-1:0] dec_sample
);
    localparam int XW = SAMPLE_W + 2;
    localparam logic signed [XW-1:0] LIM = XW'(STEP_MAX);

    logic signed [SAMPLE_W-1:0] est_prev_q;
    logic signed [XW-1:0]       est_diff;

    // Keep last cycle's estimate for the step-size bound.
    always_ff @(posedge clk) begin
        if (!rst_n) est_prev_q <= '0;
        else        est_prev_q <= enc_est;
    end

    // Change of the estimate across the last edge.
    always_comb est_diff = {{2{enc_est[SAMPLE_W-1]}}, enc_est}
                         - {{2{est_prev_q[SAMPLE_W-1]}}, est_prev_q};

    // R1
    bit_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (sample_in >= enc_est)) |=> enc_bit);
    // R1
    bit_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (sample_in < enc_est)) |=> !enc_bit);
    // R2
    est_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> (enc_bit ? (est_diff >= 0) : (est_diff <= 0)));
    // R5
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> ((est_diff <= LIM) && (est_diff >= -LIM)));
    // R8
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(enc_est) && $stable(enc_bit)));
    // R8
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> $stable(dec_sample));
endmodule

bind adm_codec adm_codec_checker #(
    .SAMPLE_W(SAMPLE_W),
    .STEP_MAX(STEP_MAX)
) u_adm_codec_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .sample_in   (sample_in),
    .enc_bit     (enc_bit),
    .enc_est     (enc_est),
    .dec_valid   (dec_valid),
    .dec_sample  (dec_sample)
);

// File: tb/adm_codec_bench.sv
`timescale 1ns/1ps
// Self-checking bench for adm_codec: directed corners plus seeded random
// samples, compared against a behavioural model of both codec sides.
module adm_codec_bench;
    localparam int SW   = 16;
    localparam int SMIN = 8;
    localparam int SMAX = 8192;
    localparam int EHI  = 32767;
    localparam int ELO  = -32768;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] sample_in = '0;
    logic                 enc_bit;
    logic signed [SW-1:0] enc_est;
    logic                 dec_valid = 1'b0;
    logic                 dec_bit = 1'b0;
    logic signed [SW-1:0] dec_sample;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state: encoder and decoder sides.
    int m_est, m_step;
    bit m_prev;
    int d_est, d_step;
    bit d_prev;
    bit corrupted;

    adm_codec #(.SAMPLE_W(SW), .STEP_W(15), .STEP_MIN(SMIN), .STEP_MAX(SMAX)) u_adm_codec (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
        .enc_bit(enc_bit), .enc_est(enc_est), .dec_valid(dec_valid), .dec_bit(dec_bit),
        .dec_sample(dec_sample)
    );

    always #2 clk = ~clk;

    function automatic int next_step(int s, bit same);
        int r;
        r = same ? (s + (s >> 1)) : ((s >> 1) + (s >> 3) + (s >> 5));
        if (r > SMAX) r = SMAX;
        if (r < SMIN) r = SMIN;
        return r;
    endfunction

    function automatic int next_est(int e, int s, bit up);
        int r;
        r = up ? (e + s) : (e - s);
        if (r > EHI) r = EHI;
        if (r < ELO) r = ELO;
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_est = 0; m_step = SMIN; m_prev = 1'b0;
        d_est = 0; d_step = SMIN; d_prev = 1'b0;
        corrupted = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_valid = 1'b0;
        dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R7: all outputs at their reset values
        check("R7 enc_bit", int'(enc_bit), 0);
        check("R7 enc_est", int'(enc_est), 0);
        check("R7 dec_sample", int'(dec_sample), 0);
    endtask

    // One sample through the encoder, then its (optionally flipped) bit through the decoder.
    task automatic apply(int s, bit flip);
        bit    eb;
        bit    same;
        int    raw;
        string tag;
        eb   = (s >= m_est);
        same = (eb == m_prev);
        m_step = next_step(m_step, same);
        raw  = eb ? (m_est + m_step) : (m_est - m_step);
        m_est = next_est(m_est, m_step, eb);
        m_prev = eb;
        if (raw > EHI || raw < ELO)          tag = "R6";
        else if (m_step == SMAX || m_step == SMIN) tag = "R5 R2";
        else if (same)                       tag = "R2 R3";
        else                                 tag = "R2 R4";

        @(negedge clk);
        sample_valid = 1'b1;
        sample_in = SW'(s);
        @(negedge clk);
        sample_valid = 1'b0;
        sample_in = SW'($urandom);
        check("R1 enc_bit", int'(enc_bit), int'(eb));
        check(tag, int'(enc_est), m_est);

        if (flip) corrupted = 1'b1;
        dec_valid = 1'b1;
        dec_bit = eb ^ flip;
        d_step = next_step(d_step, (dec_bit == d_prev));
        d_est = next_est(d_est, d_step, dec_bit);
        d_prev = dec_bit;
        @(negedge clk);
        dec_valid = 1'b0;
        dec_bit = $urandom;
        check(corrupted ? "R10 dec_sample" : "R9 dec_sample", int'(dec_sample), d_est);
    endtask

    // Idle cycles with changing inputs: nothing may move.
    task automatic idle_check(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            sample_in = SW'($urandom);
            dec_bit = $urandom;
        end
        @(negedge clk);
        // R8: outputs held without strobes
        check("R8 enc_est", int'(enc_est), m_est);
        check("R8 enc_bit", int'(enc_bit), int'(m_prev));
        check("R8 dec_sample", int'(dec_sample), d_est);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // Flat zero input: alternating bits, step shrinks to minimum (R4, R5).
        for (int i = 0; i < 12; i++) apply(0, 1'b0);
        idle_check(5);

        // Full-scale positive: runs grow the step, hit max and saturate (R3, R5, R6).
        for (int i = 0; i < 20; i++) apply(EHI, 1'b0);
        // Full-scale negative: swing to the lower limit.
        for (int i = 0; i < 24; i++) apply(ELO, 1'b0);
        idle_check(3);

        // Slow ramp up and down.
        for (int i = 0; i < 40; i++) apply(-2000 + i * 100, 1'b0);
        for (int i = 0; i < 40; i++) apply(2000 - i * 100, 1'b0);

        // Random samples.
        for (int i = 0; i < 120; i++) apply(int'($urandom_range(65535)) - 32768, 1'b0);

        // Mid-run reset returns both sides to the start state (R7).
        do_reset();
        for (int i = 0; i < 6; i++) apply(500, 1'b0);

        // Corrupted bits: decoder keeps decoding the stream as received (R10).
        for (int i = 0; i < 60; i++) apply(int'($urandom_range(8000)) - 4000, (i == 10) || (i == 35));
        idle_check(4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule